// File: doc/BRIEF.md
# Coarse/Fine Trigger Delay Controller

This block schedules one delayed output edge for each incoming trigger. The delay request is an unsigned count of 10 ps steps. It is split into a whole number of local clock cycles, which the block counts itself, and a residual code for an external fine delay element. When the count runs out, the block raises a fire strobe and presents the residual code in the same clock cycle. The local clock is phase locked to the 10 MHz reference. The default period is 2500 steps (40 MHz), so the residual never exceeds one period.

**Net delay.** The trigger does not arrive aligned to the clock. An external measurement reports the time from the trigger to the clock edge that sampled it, in the same 10 ps units. That result only appears a few hundred nanoseconds later. The block therefore starts counting at once and subtracts the phase whenever it arrives. It also subtracts a fixed calibrated path offset. The cycle count and residual code then land the output edge on the requested time.

**Short requests.** A request shorter than the measurement latency cannot wait for the phase. Such a request is steered to a separate direct fine-delay path, and an output multiplexer select is set accordingly.

**Phase input handshake.** The phase result enters on a valid/ready stream. Ready is high only while a coarse delay is running and its phase has not yet been taken. The source must hold valid and data until ready is seen. A phase offered while ready is low is neither consumed nor stored. Exactly one phase is accepted per delay. Trigger, fire, direct, select and status pins are plain strobes and levels.

Top module: `tdly_ctrl`

## Requirements
- R1: A request D ≥ SHORT_STEPS (30000) is accepted on the clock edge where trig_i is high, called edge 0. The net delay is N = D − phase − OFFSET_STEPS (150). If the phase handshake completes at or before edge k = N / PERIOD_STEPS (2500), fire_o is high for one cycle after edge k. In that same cycle fine_code_o = N mod PERIOD_STEPS.
- R2: fine_code_o always lies in 0..PERIOD_STEPS−1. It changes only in a cycle where fire_o is high and holds its value otherwise.
- R3: A request D < SHORT_STEPS accepted at edge 0 makes direct_o high for one cycle after edge 0, with direct_code_o = D and path_sel_o = 1. No coarse delay starts (busy_o stays 0).
- R4: An accepted request D ≥ SHORT_STEPS sets path_sel_o = 0 after edge 0. path_sel_o keeps its value until the next accepted trigger.
- R5: phase_ready_o is high only from the cycle after an accepted long request until the edge where a phase is accepted. A phase_valid_i while phase_ready_o is low has no effect.
- R6: busy_o is 1 from the cycle after a long request is accepted until the cycle in which fire_o or late_o is high. In that cycle it is already 0.
- R7: A trigger while busy_o is 1 is dropped. overrun_o is high for one cycle after that edge. path_sel_o and direct_o do not change, and the running delay fires exactly as it would have otherwise.
- R8: If the remaining time would go below zero, late_o is high for one cycle and fire_o does not rise for that trigger. This happens either because the phase arrived after the firing edge, or because the request minus the offset has been used up with no phase yet.
- R9: A phase accepted on the very edge that fires is included in that fire's residual code.
- R10: After reset, fire_o, direct_o, late_o, overrun_o, busy_o, phase_ready_o, path_sel_o and fine_code_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, locked to the frequency reference |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Trigger sampled on this clock edge |
| delay_i | input | DELAY_W | Requested delay in 10 ps steps, taken with trig_i |
| phase_valid_i | input | 1 | Measured trigger phase is offered |
| phase_ready_o | output | 1 | Block can take the phase now |
| phase_i | input | PH_W | Trigger-to-sampling-edge time in 10 ps steps |
| fire_o | output | 1 | Coarse count done; one-cycle strobe |
| fine_code_o | output | PH_W | Residual code for the fine element, registered with fire_o |
| direct_o | output | 1 | Short request steered to the direct path; one-cycle strobe |
| direct_code_o | output | SHORT_W | Delay code for the direct path |
| path_sel_o | output | 1 | Output multiplexer select: 0 coarse path, 1 direct path |
| busy_o | output | 1 | A coarse delay is running |
| overrun_o | output | 1 | A trigger was dropped because the block was busy |
| late_o | output | 1 | A coarse delay could not be met and was abandoned |

## Verification
**Split arithmetic.** The bench targets nets that are exact multiples of the period, and nets one step short of the next multiple. A design with an off-by-one in the split would fire one cycle early or late, or output a code of 2500 instead of 0.

**Thresholds.** Requests at exactly 30000 and at 29999 steps check the short/long threshold. A wrong comparison would send a boundary request down the wrong path and flip the select.

**Phase timing.** A phase can arrive exactly on the firing edge, and it can arrive too late. A design that ignored the phase taken on that edge would emit a wrong residual. A design without the late check would fire with a wrapped negative code.

**Ignored inputs.** A phase offered while idle, and a trigger arriving mid-delay, must both leave the running delay's cycle and code untouched.

// File: rtl/tdly_pkg.sv
package tdly_pkg;
  // Output multiplexer choice; the encoding is visible on path_sel_o.
  typedef enum logic {
    PATH_COARSE = 1'b0,
    PATH_DIRECT = 1'b1
  } path_e;
endpackage

// File: rtl/tdly_route.sv
// Accepts or drops triggers and steers short requests to the direct path.
module tdly_route
  import tdly_pkg::*;
#(
  parameter int DELAY_W     = 40,
  parameter int SHORT_STEPS = 30000,
  parameter int SHORT_W     = $clog2(SHORT_STEPS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig_i,
  input  logic [DELAY_W-1:0] delay_i,
  input  logic               busy_i,
  output logic               start_o,
  output logic               direct_o,
  output logic [SHORT_W-1:0] direct_code_o,
  output logic               path_sel_o,
  output logic               overrun_o
);
  logic  is_short;
  logic  accept;
  logic  direct_q;
  logic  overrun_q;
  logic  [SHORT_W-1:0] code_q;
  path_e path_q;

  assign is_short = delay_i < DELAY_W'(SHORT_STEPS);
  assign accept   = trig_i & ~busy_i;
  assign start_o  = accept & ~is_short;

  always_ff @(posedge clk) begin
    if (rst) begin
      direct_q  <= 1'b0;
      overrun_q <= 1'b0;
      code_q    <= '0;
      path_q    <= PATH_COARSE;
    end else begin
      direct_q  <= accept & is_short;
      overrun_q <= trig_i & busy_i;
      if (accept) begin
        path_q <= is_short ? PATH_DIRECT : PATH_COARSE;
        if (is_short) code_q <= delay_i[SHORT_W-1:0];
      end
    end
  end

  assign direct_o      = direct_q;
  assign direct_code_o = code_q;
  assign path_sel_o    = path_q;
  assign overrun_o     = overrun_q;

  // R7
  overrun_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_i && busy_i) |=> (overrun_q && !direct_q && $stable(path_q)));

  // R3
  direct_steer_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_i && !busy_i && is_short) |=> (direct_q && path_q == PATH_DIRECT));

  // R4
  path_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(trig_i && !busy_i) |=> $stable(path_q));
endmodule

// File: rtl/tdly_accum.sv
// Running step accumulator: counts down whole periods, absorbs the phase
// once, and fires when the remainder falls inside one period.
module tdly_accum #(
  parameter int DELAY_W      = 40,
  parameter int PERIOD_STEPS = 2500,
  parameter int OFFSET_STEPS = 150,
  parameter int PH_W         = $clog2(PERIOD_STEPS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [DELAY_W-1:0] delay_i,
  input  logic               phase_valid_i,
  input  logic [PH_W-1:0]    phase_i,
  output logic               phase_ready_o,
  output logic               busy_o,
  output logic               fire_o,
  output logic [PH_W-1:0]    fine_code_o,
  output logic               late_o
);
  localparam int ACC_W = DELAY_W + 2;

  logic             armed_q, got_q, fire_q, late_q;
  logic [ACC_W-1:0] acc_q, load_v, sub_v, nxt;
  logic [PH_W-1:0]  fine_q;
  logic             take, known, neg, in_period;

  // Calibrated offset removal; skipped entirely when the offset is zero.
  generate
    if (OFFSET_STEPS == 0) begin : g_no_ofs
      assign load_v = ACC_W'(delay_i);
    end else begin : g_ofs
      assign load_v = ACC_W'(delay_i) - ACC_W'(OFFSET_STEPS);
    end
  endgenerate

  assign phase_ready_o = armed_q & ~got_q;
  assign take          = phase_valid_i & phase_ready_o;
  assign known         = got_q | take;
  assign sub_v         = ACC_W'(PERIOD_STEPS) + (take ? ACC_W'(phase_i) : '0);
  assign nxt           = acc_q - sub_v;
  assign neg           = nxt[ACC_W-1];
  assign in_period     = nxt < ACC_W'(PERIOD_STEPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      got_q   <= 1'b0;
      acc_q   <= '0;
      fire_q  <= 1'b0;
      late_q  <= 1'b0;
      fine_q  <= '0;
    end else begin
      fire_q <= 1'b0;
      late_q <= 1'b0;
      if (start_i) begin
        armed_q <= 1'b1;
        got_q   <= 1'b0;
        acc_q   <= load_v;
      end else if (armed_q) begin
        if (known && in_period) begin
          fire_q  <= 1'b1;
          fine_q  <= nxt[PH_W-1:0];
          armed_q <= 1'b0;
        end else if (neg) begin
          late_q  <= 1'b1;
          armed_q <= 1'b0;
        end else begin
          acc_q <= nxt;
          got_q <= known;
        end
      end
    end
  end

  assign busy_o      = armed_q;
  assign fire_o      = fire_q;
  assign late_o      = late_q;
  assign fine_code_o = fine_q;

  // R2
  fine_range_chk: assert property (@(posedge clk) disable iff (rst)
    fire_q |-> ({1'b0, fine_q} < (PH_W+1)'(PERIOD_STEPS)));

  // R2
  fine_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fire_q |-> $stable(fine_q));

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(armed_q) |-> (fire_q || late_q));

  // R5
  ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    phase_ready_o |-> armed_q);

  // R8
  single_event_chk: assert property (@(posedge clk) disable iff (rst)
    (fire_q || late_q) |=> !(fire_q || late_q));
endmodule

// File: rtl/tdly_ctrl.sv
// Top: coarse/fine trigger delay controller.
module tdly_ctrl #(
  parameter int DELAY_W      = 40,
  parameter int PERIOD_STEPS = 2500,
  parameter int OFFSET_STEPS = 150,
  parameter int SHORT_STEPS  = 30000,
  localparam int PH_W        = $clog2(PERIOD_STEPS),
  localparam int SHORT_W     = $clog2(SHORT_STEPS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig_i,
  input  logic [DELAY_W-1:0] delay_i,
  input  logic               phase_valid_i,
  output logic               phase_ready_o,
  input  logic [PH_W-1:0]    phase_i,
  output logic               fire_o,
  output logic [PH_W-1:0]    fine_code_o,
  output logic               direct_o,
  output logic [SHORT_W-1:0] direct_code_o,
  output logic               path_sel_o,
  output logic               busy_o,
  output logic               overrun_o,
  output logic               late_o
);
  logic start;
  logic busy;

  tdly_route #(
    .DELAY_W    (DELAY_W),
    .SHORT_STEPS(SHORT_STEPS),
    .SHORT_W    (SHORT_W)
  ) u_route (
    .clk          (clk),
    .rst          (rst),
    .trig_i       (trig_i),
    .delay_i      (delay_i),
    .busy_i       (busy),
    .start_o      (start),
    .direct_o     (direct_o),
    .direct_code_o(direct_code_o),
    .path_sel_o   (path_sel_o),
    .overrun_o    (overrun_o)
  );

  tdly_accum #(
    .DELAY_W     (DELAY_W),
    .PERIOD_STEPS(PERIOD_STEPS),
    .OFFSET_STEPS(OFFSET_STEPS),
    .PH_W        (PH_W)
  ) u_accum (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start),
    .delay_i      (delay_i),
    .phase_valid_i(phase_valid_i),
    .phase_i      (phase_i),
    .phase_ready_o(phase_ready_o),
    .busy_o       (busy),
    .fire_o       (fire_o),
    .fine_code_o  (fine_code_o),
    .late_o       (late_o)
  );

  assign busy_o = busy;

  // R1
  fire_not_direct_chk: assert property (@(posedge clk) disable iff (rst)
    fire_o |-> !direct_o);
endmodule

// File: tb/sim_tdly_ctrl.sv
module sim_tdly_ctrl;
  localparam int P   = 2500;
  localparam int OFS = 150;

  typedef struct packed {
    longint d;     // request, steps
    int     ph;    // phase, steps
    int     j;     // edge on which phase is offered
    int     kind;  // 0 fire, 1 late, 2 direct
    int     cyc;   // expected event edge
    int     code;  // expected fine/direct code
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{64'd40000,   700,  3, 0,  15, 1650},  // R1 typical
    '{64'd30000,     0,  2, 0,  11, 2350},  // R1/R3 threshold, long side
    '{64'd29999,     0,  0, 2,   0, 29999}, // R3 threshold, short side
    '{64'd0,         0,  0, 2,   0, 0},     // R3 zero request
    '{64'd1000000, 2499, 10, 0, 398, 2351}, // R1 long, max phase
    '{64'd50150,     0,  1, 0,  20, 0},     // R2 exact multiple
    '{64'd52649,     0,  1, 0,  20, 2499},  // R2 top of range
    '{64'd32650,     0, 14, 1,  14, 0},     // R8 phase too late
    '{64'd32650,  2000, 13, 1,  13, 0},     // R8 phase pushes negative
    '{64'd38650,  1000, 15, 0,  15, 0}      // R9 phase on firing edge
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        trig;
  logic [39:0] dly;
  logic        pv;
  logic        pr;
  logic [11:0] ph;
  logic        fire;
  logic [11:0] fine;
  logic        direct;
  logic [14:0] dcode;
  logic        psel;
  logic        busy;
  logic        ovr;
  logic        late;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tdly_ctrl u0 (
    .clk          (clk),
    .rst          (rst),
    .trig_i       (trig),
    .delay_i      (dly),
    .phase_valid_i(pv),
    .phase_ready_o(pr),
    .phase_i      (ph),
    .fire_o       (fire),
    .fine_code_o  (fine),
    .direct_o     (direct),
    .direct_code_o(dcode),
    .path_sel_o   (psel),
    .busy_o       (busy),
    .overrun_o    (ovr),
    .late_o       (late)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Applies one vector; returns at the negedge after its event.
  task automatic run_vec(input vec_t v, input int ovr_at);
    int  c;
    bit  got;
    bit  was_fire;
    @(negedge clk);
    trig = 1'b1;
    dly  = 40'(v.d);
    @(posedge clk);
    @(negedge clk);
    trig = 1'b0;
    if (v.kind == 2) begin
      chk(direct == 1'b1, "R3 direct strobe", longint'(direct), 1);
      chk(dcode == 15'(v.code), "R3 direct code", longint'(dcode), v.code);
      chk(psel == 1'b1 && busy == 1'b0, "R3 select/busy", longint'({psel, busy}), 2);
      return;
    end
    chk(psel == 1'b0, "R4 coarse select", longint'(psel), 0);
    chk(busy == 1'b1 && pr == 1'b1, "R6 busy and R5 ready", longint'({busy, pr}), 3);
    got      = 1'b0;
    was_fire = 1'b0;
    c        = 0;
    while (!got && c < 2000) begin
      c++;
      pv   = (c == v.j);
      ph   = 12'(v.ph);
      trig = (c == ovr_at);
      dly  = 40'd100;
      @(posedge clk);
      @(negedge clk);
      pv   = 1'b0;
      trig = 1'b0;
      if (c == ovr_at) begin
        chk(ovr == 1'b1 && direct == 1'b0 && psel == 1'b0,
            "R7 overrun dropped", longint'({ovr, direct, psel}), 4);
      end
      if (fire || late) begin
        got      = 1'b1;
        was_fire = fire;
      end else if (c == v.j) begin
        chk(pr == 1'b0, "R5 ready after take", longint'(pr), 0);
      end
    end
    if (v.kind == 0) begin
      chk(was_fire, "R1 fire event", longint'(was_fire), 1);
      chk(c == v.cyc, (v.j == v.cyc) ? "R9 fire edge" : "R1 fire edge", c, v.cyc);
      chk(fine == 12'(v.code), (v.j == v.cyc) ? "R9 residual" : "R1 residual",
          longint'(fine), v.code);
    end else begin
      chk(got && !was_fire, "R8 late event", longint'(was_fire), 0);
      chk(c == v.cyc, "R8 late edge", c, v.cyc);
    end
    chk(busy == 1'b0, "R6 busy clear", longint'(busy), 0);
    @(negedge clk);
    chk(fire == 1'b0 && fine == (v.kind == 0 ? 12'(v.code) : fine),
        "R2 code held", longint'(fine), v.code);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst  = 1'b1;
    trig = 1'b0;
    dly  = '0;
    pv   = 1'b0;
    ph   = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk({fire, direct, late, ovr, busy, pr, psel} == 7'b0 && fine == 12'd0,
        "R10 reset outputs", longint'({fire, direct, late, ovr, busy, pr, psel}), 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], -1);

    // R5: phase offered while idle is ignored; then an exact-multiple run must be unchanged.
    @(negedge clk);
    pv = 1'b1;
    ph = 12'd2000;
    repeat (3) @(negedge clk);
    chk(pr == 1'b0, "R5 idle not ready", longint'(pr), 0);
    run_vec(VEC[5], -1);

    // R7: trigger mid-delay is dropped and the running delay is unaffected.
    run_vec(VEC[0], 5);

    // R4: after a direct request, a long one sets the select back to coarse.
    run_vec(VEC[2], -1);
    run_vec(VEC[1], -1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule